// File: doc/BRIEF.md
# Multi-Channel PWM LED Output Stage

This block turns a bank of per-channel brightness settings into pulse-width enables for a row of constant-current LED sinks. Every channel holds an 8-bit duty byte, a 2-bit current-scale code and an on/off bit. One free-running 8-bit phase counter is shared by all channels, and a channel's enable is high while the counter is below that channel's captured duty value. The result is 256 brightness steps per channel. A programmable prescaler sets how many clock cycles each counter step lasts.

Three independent kill paths turn every enable off at once: a software run bit (0 = shut down), a global-disable bit (1 = all dark) and an active-low shutdown pin. None of them clears any setting. Duty and scale values are captured only at the counter wrap, so the stage never emits a truncated or doubled pulse within a period. The scale code is forwarded to the analog current sinks.

Top module: `led_pwm_bank`

## Requirements
- R1: While reset is held, and on the first cycle after it, every `pwm_en` bit is 0 and every `scale_out` field is 0.
- R2: With a duty value D captured and no kill active, a channel's `pwm_en` is high for exactly D×(tick_div+1) cycles in every window of 256×(tick_div+1) consecutive cycles. D=0 never goes high and D=255 is high for 255 of 256 steps.
- R3: Each channel's high time depends only on its own duty byte. Channel k uses bits [8k+7:8k] of `duty_flat`.
- R4: When a channel's `chan_on` bit is 0, its `pwm_en` is 0 from the next cycle on, whatever its duty.
- R5: `sw_run`=0 forces all `pwm_en` bits to 0 from the next cycle on. Duty and scale settings are kept, and a duty changed during shutdown is still captured.
- R6: `hw_sd_n`=0 forces all `pwm_en` bits to 0 from the next cycle on, and settings are kept.
- R7: `glob_off`=1 forces all `pwm_en` bits to 0 from the next cycle on, and settings are kept.
- R8: `scale_out` bits [2k+1:2k] carry channel k's captured scale code: 0 = full, 1 = half, 2 = third, 3 = quarter current.
- R9: The phase counter advances once every tick_div+1 clock cycles.
- R10: Duty and scale inputs are captured only in the cycle where the counter steps from 255 to 0. A change made in mid-period has no effect on outputs until the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_div | input | 16 | Prescaler: counter steps every tick_div+1 cycles |
| sw_run | input | 1 | Software run bit, 0 shuts all outputs off |
| glob_off | input | 1 | Global disable, 1 shuts all outputs off |
| hw_sd_n | input | 1 | Shutdown pin, active low, synchronous to clk |
| chan_on | input | 36 | Per-channel on/off bit |
| duty_flat | input | 288 | Per-channel duty bytes, channel k at [8k+7:8k] |
| scale_flat | input | 72 | Per-channel scale codes, channel k at [2k+1:2k] |
| pwm_en | output | 36 | Per-channel PWM enable |
| scale_out | output | 72 | Captured scale codes to the current sinks |

## Verification
Two functions can act in the same cycle: the period-wrap capture of new duty values and a shutdown that is active. The bench writes a new duty value while software shutdown holds all outputs dark, keeps shutdown active across a wrap, and then releases it. The following period must show the new high time, which proves the capture went ahead. An untouched channel must show its old high time, which proves that shutdown cleared nothing.

// File: rtl/led_pwm_pkg.sv
// Package: shared widths and types for the PWM LED output stage.
// Assumes 8-bit duty resolution and 2-bit current-scale codes throughout.
package led_pwm_pkg;
    localparam int DUTY_W  = 8;
    localparam int SCALE_W = 2;

    typedef logic [DUTY_W-1:0]  duty_t;
    typedef logic [SCALE_W-1:0] scale_t;

    // Current-scale encoding forwarded to the analog sinks.
    typedef enum logic [SCALE_W-1:0] {
        SCL_FULL    = 2'd0,
        SCL_HALF    = 2'd1,
        SCL_THIRD   = 2'd2,
        SCL_QUARTER = 2'd3
    } scale_e;
endpackage

// File: rtl/led_pwm_timebase.sv
// Timebase: prescaler plus the shared phase counter.
// The counter advances once every div+1 cycles. wrap marks the step from the
// top count back to zero. Assumes div may change at any time; the prescaler
// then restarts cleanly because it compares with >=.
module led_pwm_timebase
    import led_pwm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output duty_t            phase,
    output logic             wrap
);
    logic [DIV_W-1:0] pre_q;
    logic             tick;

    // Tick whenever the prescaler has reached the divider value.
    assign tick = (pre_q >= div);
    assign wrap = tick && (phase == '1);

    // Advance the prescaler and step the phase counter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            phase <= '0;
        end else if (tick) begin
            pre_q <= '0;
            phase <= phase + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R9: the counter holds between ticks.
    p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
    // R10: a wrap always lands the counter at zero.
    p_wrap_to_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (phase == '0));
endmodule

// File: rtl/led_pwm_kill.sv
// Kill combiner: merges the three shutdown sources into one dark request.
// Assumes all three inputs are synchronous to clk.
module led_pwm_kill (
    input  logic sw_run,
    input  logic glob_off,
    input  logic hw_sd_n,
    output logic kill
);
    // Any single source is enough to darken every channel.
    always_comb kill = !sw_run || glob_off || !hw_sd_n;
endmodule

// File: rtl/led_pwm_chan.sv
// One channel: captures duty and scale at the period wrap and compares the
// shared phase with the captured duty to form a registered enable.
// Assumes wrap is a single-cycle pulse from the timebase.
module led_pwm_chan
    import led_pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  duty_t  phase,
    input  logic   wrap,
    input  logic   kill,
    input  logic   on,
    input  duty_t  duty_in,
    input  scale_t scale_in,
    output logic   pwm,
    output scale_t scale_q
);
    duty_t duty_q;

    // Take new settings only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q  <= '0;
            scale_q <= '0;
        end else if (wrap) begin
            duty_q  <= duty_in;
            scale_q <= scale_in;
        end
    end

    // Registered enable: high while the phase is below the captured duty.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm <= 1'b0;
        else        pwm <= !kill && on && (phase < duty_q);
    end

    // R4: a channel that is switched off is dark on the next cycle.
    p_off_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> !pwm);
    // R2: a zero duty never lights the channel.
    p_zero_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |=> !pwm);
    // R10: captured settings move only at the wrap.
    p_capture_at_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(duty_q) && $stable(scale_q)));
endmodule

// File: rtl/led_pwm_bank.sv
// Top: multi-channel PWM LED output stage. One timebase feeds NCH channel
// slices, and a kill combiner can darken every channel at once.
// Assumes all inputs are synchronous to clk.
module led_pwm_bank
    import led_pwm_pkg::*;
#(
    parameter int NCH   = 36,
    parameter int DIV_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DIV_W-1:0]       tick_div,
    input  logic                   sw_run,
    input  logic                   glob_off,
    input  logic                   hw_sd_n,
    input  logic [NCH-1:0]         chan_on,
    input  logic [NCH*DUTY_W-1:0]  duty_flat,
    input  logic [NCH*SCALE_W-1:0] scale_flat,
    output logic [NCH-1:0]         pwm_en,
    output logic [NCH*SCALE_W-1:0] scale_out
);
    duty_t phase;
    logic  wrap;
    logic  kill;

    led_pwm_timebase #(.DIV_W(DIV_W)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (tick_div),
        .phase (phase),
        .wrap  (wrap)
    );

    led_pwm_kill u_kill (
        .sw_run   (sw_run),
        .glob_off (glob_off),
        .hw_sd_n  (hw_sd_n),
        .kill     (kill)
    );

    // One slice per channel, each with its own field of the flat buses.
    for (genvar k = 0; k < NCH; k++) begin : g_chan
        led_pwm_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .phase    (phase),
            .wrap     (wrap),
            .kill     (kill),
            .on       (chan_on[k]),
            .duty_in  (duty_flat[k*DUTY_W +: DUTY_W]),
            .scale_in (scale_flat[k*SCALE_W +: SCALE_W]),
            .pwm      (pwm_en[k]),
            .scale_q  (scale_out[k*SCALE_W +: SCALE_W])
        );
    end

    // R5: software shutdown darkens everything next cycle.
    p_sw_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_run |=> (pwm_en == '0));
    // R6: the shutdown pin darkens everything next cycle.
    p_pin_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_sd_n |=> (pwm_en == '0));
    // R7: global disable darkens everything next cycle.
    p_glob_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        glob_off |=> (pwm_en == '0));
    // R1: outputs come out of reset dark and unscaled.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> ((pwm_en == '0) && (scale_out == '0)));
endmodule

// File: tb/led_pwm_bank_bench.sv
module led_pwm_bank_bench;
    localparam int NCH = 36;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [15:0]     tick_div = '0;
    logic            sw_run = 1'b1;
    logic            glob_off = 1'b0;
    logic            hw_sd_n = 1'b1;
    logic [NCH-1:0]  chan_on = '1;
    logic [NCH*8-1:0] duty_flat = '0;
    logic [NCH*2-1:0] scale_flat = '0;
    logic [NCH-1:0]  pwm_en;
    logic [NCH*2-1:0] scale_out;

    int checks = 0;
    int failures = 0;

    led_pwm_bank u_led_pwm_bank (
        .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .sw_run(sw_run),
        .glob_off(glob_off), .hw_sd_n(hw_sd_n), .chan_on(chan_on),
        .duty_flat(duty_flat), .scale_flat(scale_flat),
        .pwm_en(pwm_en), .scale_out(scale_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic set_duty(input int ch, input int v);
        duty_flat[ch*8 +: 8] = 8'(v);
    endtask

    task automatic count_high(input int ch, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_en[ch]) c++;
        end
    endtask

    task automatic count_any(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_en != '0) c++;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_en[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_en[ch]) break;
            prev = pwm_en[ch];
        end
    endtask

    task automatic t_reset();
        settle(3);
        check("R1 pwm in reset", pwm_en, 0);
        check("R1 scale in reset", scale_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pwm after reset", pwm_en, 0);
    endtask

    task automatic t_duty();
        int c;
        set_duty(0, 0); set_duty(1, 1); set_duty(2, 128);
        set_duty(3, 255); set_duty(5, 77);
        settle(260);
        count_high(0, 256, c); check("R2 duty 0", c, 0);
        count_high(1, 256, c); check("R2 duty 1", c, 1);
        count_high(2, 256, c); check("R2 duty 128", c, 128);
        count_high(3, 256, c); check("R2 duty 255", c, 255);
        count_high(5, 256, c); check("R3 independent duty 77", c, 77);
        count_high(6, 256, c); check("R3 untouched channel", c, 0);
    endtask

    task automatic t_prescale();
        int c;
        tick_div = 16'd2;
        settle(3*256 + 4);
        count_high(2, 768, c); check("R9 div2 duty 128", c, 384);
        count_high(3, 768, c); check("R9 div2 duty 255", c, 765);
        tick_div = 16'd0;
        settle(3*256 + 4);
    endtask

    task automatic t_onbit();
        int c;
        chan_on[3] = 1'b0;
        @(negedge clk);
        check("R4 off next cycle", pwm_en[3], 0);
        count_high(3, 256, c); check("R4 off period", c, 0);
        chan_on[3] = 1'b1;
        @(negedge clk);
        count_high(3, 256, c); check("R4 back on", c, 255);
    endtask

    task automatic t_shutdowns();
        int c;
        // R5 software shutdown, with a duty change captured while dark
        sw_run = 1'b0;
        @(negedge clk);
        check("R5 sw dark next cycle", pwm_en, 0);
        set_duty(2, 64);
        count_any(300, c); check("R5 sw dark window", c, 0);
        sw_run = 1'b1;
        @(negedge clk);
        count_high(2, 256, c); check("R5 duty captured during shutdown", c, 64);
        count_high(3, 256, c); check("R5 settings kept", c, 255);
        // R6 pin shutdown
        hw_sd_n = 1'b0;
        @(negedge clk);
        check("R6 pin dark next cycle", pwm_en, 0);
        count_any(256, c); check("R6 pin dark window", c, 0);
        hw_sd_n = 1'b1;
        @(negedge clk);
        count_high(5, 256, c); check("R6 settings kept", c, 77);
        // R7 global disable
        glob_off = 1'b1;
        @(negedge clk);
        check("R7 global dark next cycle", pwm_en, 0);
        count_any(256, c); check("R7 global dark window", c, 0);
        glob_off = 1'b0;
        @(negedge clk);
        count_high(3, 256, c); check("R7 settings kept", c, 255);
    endtask

    task automatic t_scale();
        wait_rise(3);
        scale_flat[3*2 +: 2] = 2'd2;
        scale_flat[4*2 +: 2] = 2'd3;
        @(negedge clk);
        check("R10 scale held mid-period", scale_out[3*2 +: 2], 0);
        settle(300);
        check("R8 scale third ch3", scale_out[3*2 +: 2], 2);
        check("R8 scale quarter ch4", scale_out[4*2 +: 2], 3);
        check("R8 ch0 stays full", scale_out[0 +: 2], 0);
    endtask

    task automatic t_glitch();
        int c;
        wait_rise(3);
        set_duty(3, 5);
        settle(100);
        check("R10 old duty held mid-period", pwm_en[3], 1);
        wait_rise(3);
        count_high(3, 256, c); check("R10 new duty next period", c, 5);
    endtask

    initial begin
        t_reset();
        t_duty();
        t_prescale();
        t_onbit();
        t_shutdowns();
        t_scale();
        t_glitch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8*150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule